// File: doc/BRIEF.md
# E1 timeslot-to-loop distributor

This block takes a framed E1 bit stream and splits its 32 timeslots across two or three HDSL loops. Each loop has its own FIFO. A software-written table decides which timeslot goes to which loop. The table has two copies. Software writes a shadow copy through a small register port and then sets a load bit. The shadow is copied into the active copy at the next E1 frame boundary, so one frame never uses two different mappings.

The bit strobe can come from either of two inputs: a strobe recovered from the line, or a nominal local strobe. The frame start can also come from either of two sources: an external frame-pulse input, or an internal counter that marks every 256th bit. A control bit replaces the line data with the all-ones alarm pattern (AIS). Each loop's FIFO also stores a frame-start mark with every byte. The mark sits on the first byte that loop receives in each E1 frame. This lets the loop streams downstream be re-aligned frame by frame to loop 1. Each FIFO keeps sticky overflow and underflow flags, and software can read and clear them.

Top module: `e1_ts_distributor`

## Requirements
- R1: After a synchronous active-low reset, the following all read zero: control, all three shadow maps, the active maps and the status flags. All FIFOs are empty, so nothing is routed.
- R2: Control bit 0 selects the bit strobe. When it is 0, `rec_bit_en` is the strobe; when it is 1, `nom_bit_en` is the strobe. The strobe that is not selected has no effect.
- R3: Control bit 2 selects the frame source. When it is 0, a high `ext_fp` on a strobe marks that bit as bit 0 of timeslot 0. When it is 1, `ext_fp` is ignored and a frame starts every 256 strobes.
- R4: Bits are assembled MSB first. Timeslot n is made of bits 8n to 8n+7 counted from the frame start, and bit 8n becomes byte bit 7.
- R5: When control bit 1 is set, every assembled byte is 0xFF, whatever `e1_bit` carries.
- R6: Timeslot t is written to loop k when bit t of loop k's active map is set. When several loops claim t, the lowest-numbered loop takes it. A timeslot that no loop claims is discarded.
- R7: Control bit 3 set selects three loops. When it is clear, loop 3's map is ignored and that loop receives nothing.
- R8: Register 1, 2 or 3 sets the shadow map of loop 1, 2 or 3. A shadow write does not change routing. Setting control bit 4 copies all shadows to the active maps on the next frame-start strobe. Bit 4 then reads 0.
- R9: Each loop's FIFO delivers bytes in arrival order. Bit 8 of each 9-bit entry (`lp_rd_sof`) marks the first byte that loop received in the current frame.
- R10: A write into a full FIFO is dropped and sets that loop's overflow flag (status bits 2:0). A read of an empty FIFO sets its underflow flag (status bits 6:4). The flags stay set until a 1 is written to the same bits of register 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 control, 1-3 loop maps, 4 status) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| e1_bit | input | 1 | E1 serial data bit |
| rec_bit_en | input | 1 | Bit strobe recovered from the line |
| nom_bit_en | input | 1 | Nominal local bit strobe |
| ext_fp | input | 1 | External frame pulse, sampled on the selected strobe |
| lp_rd_en | input | 3 | Per-loop FIFO pop |
| lp_empty | output | 3 | Per-loop FIFO empty |
| lp_rd_data | output | 24 | Per-loop head byte, loop k at bits 8k+7:8k |
| lp_rd_sof | output | 3 | Per-loop head frame-start mark |

## Verification
The assertions assume that a strobe only ever arrives as a single-cycle enable in the system clock domain. They also assume that software writes the control register only in whole values, never as partial updates. The bench drives the chosen strobe on every third cycle and drives the other strobe with random values. In external-frame mode it raises `ext_fp` on every 256th chosen strobe, and it starts that count off the reset phase. It pops a FIFO only while it is non-empty, except for one deliberate pop of an empty FIFO. In internal-frame mode it drives `ext_fp` at random.

// File: rtl/e1d_pkg.sv
// Package: shared sizes, register addresses and control layout for the
// E1 timeslot-to-loop distributor. Assumes an 8-bit timeslot.
package e1d_pkg;
    localparam int TS_NUM      = 32;
    localparam int TS_BITS     = 8;
    localparam int FRAME_BITS  = TS_NUM * TS_BITS;
    localparam int POS_W       = $clog2(FRAME_BITS);
    localparam int SUB_W       = $clog2(TS_BITS);
    localparam int TS_W        = $clog2(TS_NUM);
    localparam int LOOPS       = 3;

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_MAP0 = 3'd1;
    localparam logic [2:0] ADDR_STAT = 3'd4;

    typedef struct packed {
        logic load;     // bit 4: copy shadow on next frame start
        logic three;    // bit 3: three-loop mode
        logic fp_int;   // bit 2: internal frame pulse
        logic ais;      // bit 1: all-ones substitution
        logic clk_nom;  // bit 0: nominal strobe
    } ctrl_t;
endpackage

// File: rtl/e1d_bit_framer.sv
// Bit framer: picks the bit strobe and the frame source, tracks the bit
// position in the 256-bit frame and assembles timeslot bytes MSB first.
// Assumes strobes are single-cycle enables in the clk domain.
module e1d_bit_framer
    import e1d_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  ctrl_t           ctrl,
    input  logic            e1_bit,
    input  logic            rec_bit_en,
    input  logic            nom_bit_en,
    input  logic            ext_fp,
    output logic            frame_start,
    output logic            byte_valid,
    output logic [TS_W-1:0] byte_ts,
    output logic [7:0]      byte_data
);
    logic [POS_W-1:0] bitcnt;
    logic [POS_W-1:0] pos;
    logic [6:0]       shreg;
    logic             tick;
    logic             fp_now;

    // Select strobe and frame source, derive the position of this bit.
    always_comb begin
        tick        = ctrl.clk_nom ? nom_bit_en : rec_bit_en;
        fp_now      = ctrl.fp_int ? (bitcnt == '0) : ext_fp;
        pos         = fp_now ? '0 : bitcnt;
        byte_data   = {shreg, (ctrl.ais | e1_bit)};
        byte_valid  = tick && (pos[SUB_W-1:0] == '1);
        byte_ts     = pos[POS_W-1:SUB_W];
        frame_start = tick && (pos == '0);
    end

    // Advance bit counter and shift register on each selected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt <= '0;
            shreg  <= '0;
        end else if (tick) begin
            bitcnt <= pos + 1'b1;
            shreg  <= byte_data[6:0];
        end
    end

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bitcnt) && $stable(shreg)); // R2
endmodule

// File: rtl/e1d_map_table.sv
// Map table: control register plus shadow and active timeslot maps.
// Shadow is copied to active on the first frame-start strobe after the
// load bit is set; the load bit then clears itself.
module e1d_map_table
    import e1d_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [2:0]                    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    input  logic                          frame_start,
    output ctrl_t                         ctrl,
    output logic [LOOPS-1:0][TS_NUM-1:0]  shadow,
    output logic [LOOPS-1:0][TS_NUM-1:0]  active
);
    logic copy_now;

    // A copy takes place only at a frame boundary with load pending.
    always_comb copy_now = frame_start && ctrl.load;

    // Control register; software write wins over self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (cfg_we && cfg_addr == ADDR_CTRL)
            ctrl <= ctrl_t'(cfg_wdata[4:0]);
        else if (copy_now)
            ctrl.load <= 1'b0;
    end

    for (genvar k = 0; k < LOOPS; k++) begin : g_map
        // Shadow map of loop k, written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[k] <= '0;
            else if (cfg_we && cfg_addr == ADDR_MAP0 + 3'(k))
                shadow[k] <= cfg_wdata[TS_NUM-1:0];
        end

        // Active map of loop k, refreshed only at a frame boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active[k] <= '0;
            else if (copy_now)
                active[k] <= shadow[k];
        end
    end

    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.load) |-> $past(frame_start) || $past(cfg_we)); // R8
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.load |=> $stable(active)); // R8
endmodule

// File: rtl/e1d_loop_fifo.sv
// Loop FIFO: synchronous show-ahead FIFO with sticky overflow and
// underflow flags. A write into a full FIFO is dropped; a read of an
// empty FIFO leaves the state unchanged. Flags clear on request.
module e1d_loop_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    input  logic         clr_ovf,
    input  logic         clr_udf,
    output logic         ovf,
    output logic         udf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          full, push, pop;

    // Derive occupancy state and accepted operations.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push    = wr_en && !full;
        pop     = rd_en && !empty;
        rd_data = mem[rptr];
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Pointers, count and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
            udf   <= 1'b0;
        end else begin
            if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
            ovf   <= (ovf & ~clr_ovf) | (wr_en & full);
            udf   <= (udf & ~clr_udf) | (rd_en & empty);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R10
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(count) && ovf); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr_ovf) |=> ovf); // R10
    AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (udf && !clr_udf) |=> udf); // R10
endmodule

// File: rtl/e1_ts_distributor.sv
// E1 timeslot-to-loop distributor top: frames the E1 bit stream, routes
// each timeslot byte to the lowest loop whose active map claims it, tags
// each loop's first byte per frame, and exposes a register port.
// Assumes single-cycle strobes synchronous to clk.
module e1_ts_distributor
    import e1d_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 e1_bit,
    input  logic                 rec_bit_en,
    input  logic                 nom_bit_en,
    input  logic                 ext_fp,
    input  logic [LOOPS-1:0]     lp_rd_en,
    output logic [LOOPS-1:0]     lp_empty,
    output logic [LOOPS*8-1:0]   lp_rd_data,
    output logic [LOOPS-1:0]     lp_rd_sof
);
    ctrl_t                         ctrl;
    logic [LOOPS-1:0][TS_NUM-1:0]  shadow, active;
    logic                          frame_start, byte_valid;
    logic [TS_W-1:0]               byte_ts;
    logic [7:0]                    byte_data;
    logic [LOOPS-1:0]              fifo_wr, first_q, ovf, udf;
    logic [LOOPS-1:0]              clr_ovf, clr_udf;

    e1d_bit_framer u_framer (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .e1_bit(e1_bit),
        .rec_bit_en(rec_bit_en), .nom_bit_en(nom_bit_en), .ext_fp(ext_fp),
        .frame_start(frame_start), .byte_valid(byte_valid),
        .byte_ts(byte_ts), .byte_data(byte_data)
    );

    e1d_map_table u_table (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start),
        .ctrl(ctrl), .shadow(shadow), .active(active)
    );

    // Route a completed byte to the lowest enabled loop claiming it.
    always_comb begin
        logic taken;
        taken   = 1'b0;
        fifo_wr = '0;
        for (int k = 0; k < LOOPS; k++) begin
            if (!taken && active[k][byte_ts] && (k < LOOPS - 1 || ctrl.three)) begin
                fifo_wr[k] = byte_valid;
                taken      = 1'b1;
            end
        end
    end

    // Status clear strobes from a write to the status register.
    always_comb begin
        clr_ovf = (cfg_we && cfg_addr == ADDR_STAT) ? cfg_wdata[LOOPS-1:0]   : '0;
        clr_udf = (cfg_we && cfg_addr == ADDR_STAT) ? cfg_wdata[LOOPS+3:4]   : '0;
    end

    // Per-loop frame-start marks: armed at frame start, spent on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            first_q <= '0;
        else if (frame_start)
            first_q <= '1;
        else
            first_q <= first_q & ~fifo_wr;
    end

    for (genvar k = 0; k < LOOPS; k++) begin : g_loop
        e1d_loop_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(fifo_wr[k]), .wr_data({first_q[k], byte_data}),
            .rd_en(lp_rd_en[k]),
            .rd_data({lp_rd_sof[k], lp_rd_data[k*8 +: 8]}),
            .empty(lp_empty[k]),
            .clr_ovf(clr_ovf[k]), .clr_udf(clr_udf[k]),
            .ovf(ovf[k]), .udf(udf[k])
        );
    end

    // Register read multiplexer.
    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == ADDR_CTRL)
            cfg_rdata = 32'(ctrl);
        else if (cfg_addr == ADDR_STAT)
            cfg_rdata = {25'd0, udf, 1'b0, ovf};
        else if (cfg_addr >= ADDR_MAP0 && cfg_addr < ADDR_MAP0 + 3'(LOOPS))
            cfg_rdata = 32'(shadow[cfg_addr - ADDR_MAP0]);
    end

    AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_wr)); // R6
    AST_LOOP3_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.three |-> !fifo_wr[LOOPS-1]); // R7
    AST_WRITE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr != '0) |-> byte_valid); // R4
endmodule

// File: tb/e1_ts_distributor_tb.sv
// Bench: behavioural reference (queues, integers) updated every clock and
// compared against the ports at every falling edge.
module e1_ts_distributor_tb_top;
    localparam int DEPTH = 16;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] cfg_rdata;
    logic        e1_bit = 0, rec_bit_en = 0, nom_bit_en = 0, ext_fp = 0;
    logic [2:0]  lp_rd_en = 0;
    logic [2:0]  lp_empty;
    logic [23:0] lp_rd_data;
    logic [2:0]  lp_rd_sof;

    always #5 clk = ~clk;

    e1_ts_distributor dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .e1_bit(e1_bit),
        .rec_bit_en(rec_bit_en), .nom_bit_en(nom_bit_en), .ext_fp(ext_fp),
        .lp_rd_en(lp_rd_en), .lp_empty(lp_empty), .lp_rd_data(lp_rd_data),
        .lp_rd_sof(lp_rd_sof)
    );

    int checks = 0, failures = 0, cyc = 0;
    string tag = "R1";
    bit sel_nom = 0, fp_internal = 0, reads_on = 0;
    int rd_fix = -1;
    int ext_cnt = 100;

    // reference model state
    int m_bitcnt, m_sh;
    bit [4:0] m_ctrl;
    bit [31:0] m_shadow[3], m_active[3];
    int mq[3][$];
    bit [2:0] m_first, m_ovf, m_udf;

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] exp_rdata(bit [2:0] a);
        case (a)
            3'd0: return {27'd0, m_ctrl};
            3'd1, 3'd2, 3'd3: return m_shadow[a-1];
            3'd4: return {25'd0, m_udf, 1'b0, m_ovf};
            default: return 32'd0;
        endcase
    endfunction

    // Reference model step on every rising edge.
    always @(posedge clk) begin : mdl
        int osz[3];
        int pos, nb, wk;
        bit tk, fpn, bv;
        bit [2:0] oset, uset;
        if (!rst_n) begin
            m_bitcnt = 0; m_sh = 0; m_ctrl = 0; m_first = 0; m_ovf = 0; m_udf = 0;
            for (int k = 0; k < 3; k++) begin
                m_shadow[k] = 0; m_active[k] = 0; mq[k].delete();
            end
        end else begin
            for (int k = 0; k < 3; k++) osz[k] = mq[k].size();
            oset = 0; uset = 0; wk = -1; nb = 0;
            tk = m_ctrl[0] ? nom_bit_en : rec_bit_en;
            if (tk) begin
                fpn = m_ctrl[2] ? (m_bitcnt == 0) : ext_fp;
                pos = fpn ? 0 : m_bitcnt;
                bv  = m_ctrl[1] ? 1'b1 : e1_bit;
                nb  = ((m_sh << 1) | bv) & 255;
                if (pos == 0) begin
                    m_first = 3'b111;
                    if (m_ctrl[4]) begin
                        for (int k = 0; k < 3; k++) m_active[k] = m_shadow[k];
                        m_ctrl[4] = 0;
                    end
                end
                if (pos % 8 == 7)
                    for (int k = 0; k < 3; k++)
                        if (wk < 0 && m_active[k][pos/8] && (k < 2 || m_ctrl[3])) wk = k;
                m_sh = nb & 127;
                m_bitcnt = (pos + 1) % 256;
            end
            for (int k = 0; k < 3; k++)
                if (lp_rd_en[k]) begin
                    if (osz[k] > 0) void'(mq[k].pop_front());
                    else uset[k] = 1;
                end
            if (wk >= 0) begin
                if (osz[wk] < DEPTH) mq[wk].push_back({m_first[wk], nb[7:0]});
                else oset[wk] = 1;
                m_first[wk] = 0;
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_ctrl = cfg_wdata[4:0];
                    3'd1, 3'd2, 3'd3: m_shadow[cfg_addr-1] = cfg_wdata;
                    3'd4: begin
                        m_ovf = m_ovf & ~cfg_wdata[2:0];
                        m_udf = m_udf & ~cfg_wdata[6:4];
                    end
                    default: ;
                endcase
            end
            m_ovf = m_ovf | oset;
            m_udf = m_udf | uset;
        end
    end

    // Compare ports with the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(cfg_rdata == exp_rdata(cfg_addr), {"R8/R10 regs ", tag},
                  cfg_rdata, exp_rdata(cfg_addr));
            for (int k = 0; k < 3; k++) begin
                check(lp_empty[k] == (mq[k].size() == 0), {"R6 empty ", tag},
                      lp_empty[k], mq[k].size() == 0);
                if (mq[k].size() > 0)
                    check({lp_rd_sof[k], lp_rd_data[k*8 +: 8]} == 9'(mq[k][0]),
                          {"R4/R9 head ", tag}, {lp_rd_sof[k], lp_rd_data[k*8 +: 8]},
                          mq[k][0]);
            end
        end
    end

    // Background stimulus, driven just after the falling edge.
    always @(negedge clk) begin
        bit act;
        #1;
        cyc++;
        act = (cyc % 3 == 0);
        if (sel_nom) begin nom_bit_en = act; rec_bit_en = 1'($urandom); end
        else         begin rec_bit_en = act; nom_bit_en = 1'($urandom); end
        e1_bit = 1'($urandom);
        if (fp_internal) ext_fp = 1'($urandom);
        else begin
            ext_fp = act && (ext_cnt % 256 == 0);
            if (act) ext_cnt++;
        end
        for (int k = 0; k < 3; k++)
            lp_rd_en[k] = reads_on && !lp_empty[k] && ($urandom % 4 == 0);
        cfg_addr = (rd_fix >= 0) ? 3'(rd_fix) : 3'(cyc % 5);
    end

    task automatic cfg_write(bit [2:0] a, bit [31:0] d);
        @(negedge clk); #2;
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        run(4);
        @(negedge clk); #2; rst_n = 1;
        rd_fix = 0; run(2);
        // R1: reset state
        check(lp_empty == 3'b111, "R1 empty after reset", lp_empty, 3'b111);
        check(cfg_rdata == 0, "R1 ctrl after reset", cfg_rdata, 0);
        rd_fix = 4; run(2);
        check(cfg_rdata == 0, "R1 status after reset", cfg_rdata, 0);
        rd_fix = -1;

        // R8: shadow writes alone route nothing
        tag = "R8";
        cfg_write(3'd1, 32'h0000FFFF);
        cfg_write(3'd2, 32'h00FFFF00);
        cfg_write(3'd3, 32'hFF0000F0);
        run(800);
        check(lp_empty == 3'b111, "R8 no routing before load", lp_empty, 3'b111);

        // R6: load, two-loop mode, overlap resolved to lowest loop
        tag = "R6"; reads_on = 1;
        cfg_write(3'd0, 32'h10);
        run(2500);
        rd_fix = 0; run(2);
        check(cfg_rdata[4] == 0, "R8 load bit self-cleared", cfg_rdata[4], 0);
        rd_fix = -1;

        // R7: three-loop mode
        tag = "R7";
        cfg_write(3'd0, 32'h08);
        run(2000);

        // R5: all-ones substitution
        tag = "R5";
        cfg_write(3'd0, 32'h0A);
        run(1600);

        // R2: nominal strobe, recovered strobe random
        tag = "R2"; sel_nom = 1;
        cfg_write(3'd0, 32'h09);
        run(1600);

        // R3: internal frame pulse, ext_fp random
        tag = "R3"; fp_internal = 1;
        cfg_write(3'd0, 32'h0D);
        run(1600);

        // R8: mid-frame remap and load
        tag = "R8";
        cfg_write(3'd1, 32'hFFFF0000);
        run(333);
        cfg_write(3'd2, 32'h0000FFFF);
        run(111);
        cfg_write(3'd0, 32'h1D);
        run(2000);

        // R10: overflow with reads stopped
        tag = "R10"; reads_on = 0;
        cfg_write(3'd1, 32'hFFFFFFFF);
        cfg_write(3'd0, 32'h1D);
        run(2000);
        rd_fix = 4; run(2);
        check(cfg_rdata[0] == 1, "R10 overflow flag loop1", cfg_rdata[0], 1);
        rd_fix = -1;
        cfg_write(3'd1, 32'h0);
        cfg_write(3'd2, 32'h0);
        cfg_write(3'd3, 32'h0);
        cfg_write(3'd0, 32'h1D);
        run(900);
        reads_on = 1; run(400); reads_on = 0; run(4);
        check(lp_empty == 3'b111, "R10 drained", lp_empty, 3'b111);
        @(negedge clk); #2; lp_rd_en = 3'b001;
        @(negedge clk); #2; lp_rd_en = 3'b000;
        rd_fix = 4; run(2);
        check(cfg_rdata[4] == 1, "R10 underflow flag loop1", cfg_rdata[4], 1);
        cfg_write(3'd4, 32'h77);
        rd_fix = 4; run(2);
        check(cfg_rdata == 0, "R10 flags cleared", cfg_rdata, 0);
        rd_fix = -1;
        run(10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule